// File: doc/BRIEF.md
# Multiplexed-Address Strobe Sequencer for Dynamic RAM

This block sits on the controller side of a dynamic RAM interface. It takes one full-width address and a read/write select, qualified by a request strobe. It then presents the address on a bus that is half as wide, in two timed phases. The upper half of the address, the row, is placed on the bus first and is captured by the row strobe. The lower half, the column, then replaces it on the same lines and is captured by the column strobe. The memory combines the two captured halves to pick one row line and one column line, and so reaches a single cell.

Both strobes are active low and rest high. The write-enable output is active low. It is valid from the first phase of an access until the column strobe is released. A busy output covers the whole access and the precharge time that follows. A one-cycle done pulse marks the cycle in which both strobes return high. The column strobe width and the precharge length are parameters counted in clock cycles. A request is taken only while the block is idle.

Top module: `dram_addr_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, ras_n_o, cas_n_o and we_n_o are 1 and busy_o and done_o are 0. This also holds when reset arrives in the middle of an access.
- R2: A request seen at a clock edge while busy_o is 0 is accepted. In the next cycle busy_o is 1, ma_o carries the row half, and both strobes are still high.
- R3: One cycle after the row first appears, ras_n_o falls, and ma_o still carries the row half in that cycle.
- R4: In the cycle after that, ma_o switches to the column half while ras_n_o is 0 and cas_n_o is still 1. cas_n_o falls one cycle later.
- R5: cas_n_o stays at 0 for exactly CAS_CYC cycles. During this time ma_o holds the column half and ras_n_o stays at 0.
- R6: ras_n_o and cas_n_o rise in the same cycle. done_o is 1 for that one cycle only.
- R7: busy_o stays at 1 for PRE_CYC cycles counted from the strobe-rise cycle, with both strobes high. It is 0 in the cycle after that.
- R8: we_n_o is 0 for a write request (wr_i = 1) and 1 for a read (wr_i = 0). This value holds from the row-setup cycle through the last cycle with cas_n_o low. At all other times we_n_o is 1.
- R9: A request raised while busy_o is 1 is ignored. The running access keeps its address and timing, and no second access follows it.
- R10: The row half is addr_i[2*HALF_W-1:HALF_W] and the column half is addr_i[HALF_W-1:0], both taken when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2*HALF_W | Full cell address |
| ma_o | output | HALF_W | Shared row/column address bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| busy_o | output | 1 | Access or precharge in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
Take the edge that accepts a request as edge zero. Cycle 1 carries the row with strobes high. ras_n_o falls in cycle 2. The column appears in cycle 3. cas_n_o is low from cycle 4 through cycle 3+CAS_CYC. done_o and the strobe rise come at cycle 4+CAS_CYC, and busy_o drops at cycle 4+CAS_CYC+PRE_CYC. The bench computes the expected value of every output from the cycle number alone, using these offsets. It samples on the falling clock edge of each numbered cycle, so every registered state change has settled. Requests injected while busy, and a reset in the middle of an access, are checked against the same schedule.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE
    } seq_state_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic strobe_t decode_strobes(seq_state_t st, logic wr);
        strobe_t s;
        s.ras_n = 1'b1;
        s.cas_n = 1'b1;
        s.we_n  = 1'b1;
        case (st)
            ST_ROW: s.we_n = ~wr;
            ST_RAS, ST_COL: begin
                s.ras_n = 1'b0;
                s.we_n  = ~wr;
            end
            ST_CAS: begin
                s.ras_n = 1'b0;
                s.cas_n = 1'b0;
                s.we_n  = ~wr;
            end
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic drives_row(seq_state_t st);
        return (st == ST_ROW) || (st == ST_RAS);
    endfunction

endpackage

// File: rtl/dram_seq_latch.sv
module dram_seq_latch #(
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  wr_i,
    input  logic [2*HALF_W-1:0]   addr_i,
    output logic                  wr_q,
    output logic [HALF_W-1:0]     row_q,
    output logic [HALF_W-1:0]     col_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            wr_q  <= wr_i;
            row_q <= addr_i[2*HALF_W-1:HALF_W];
            col_q <= addr_i[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          expired,
    output seq_state_t    state,
    output logic          accept,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          pre_first
);
    localparam logic [CW-1:0] CAS_LOAD = CW'(CAS_CYC - 1);
    localparam logic [CW-1:0] PRE_LOAD = CW'(PRE_CYC - 1);

    seq_state_t nxt;

    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (req_i) begin
                nxt    = ST_ROW;
                accept = 1'b1;
            end
            ST_ROW: nxt = ST_RAS;
            ST_RAS: nxt = ST_COL;
            ST_COL: begin
                nxt      = ST_CAS;
                tmr_load = 1'b1;
                tmr_val  = CAS_LOAD;
            end
            ST_CAS: if (expired) begin
                nxt      = ST_PRE;
                tmr_load = 1'b1;
                tmr_val  = PRE_LOAD;
            end
            ST_PRE: if (expired) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pre_first <= 1'b0;
        end else begin
            state     <= nxt;
            pre_first <= (state == ST_CAS) && (nxt == ST_PRE);
        end
    end
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
    import dram_seq_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic                wr_i,
    input  logic [2*HALF_W-1:0] addr_i,
    output logic [HALF_W-1:0]   ma_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                we_n_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int MAX_CYC = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
    localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    seq_state_t        state;
    logic              accept, tmr_load, expired, pre_first, wr_q;
    logic [CW-1:0]     tmr_val;
    logic [HALF_W-1:0] row_q, col_q;
    strobe_t           pins;

    dram_seq_fsm #(.CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC), .CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .req_i(req_i), .expired(expired),
        .state(state), .accept(accept), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .pre_first(pre_first)
    );

    dram_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .expired(expired)
    );

    dram_seq_latch #(.HALF_W(HALF_W)) u_latch (
        .clk(clk), .rst(rst), .load(accept), .wr_i(wr_i), .addr_i(addr_i),
        .wr_q(wr_q), .row_q(row_q), .col_q(col_q)
    );

    always_comb begin
        pins    = decode_strobes(state, wr_q);
        ras_n_o = pins.ras_n;
        cas_n_o = pins.cas_n;
        we_n_o  = pins.we_n;
        ma_o    = drives_row(state) ? row_q : col_q;
        busy_o  = (state != ST_IDLE);
        done_o  = (state == ST_PRE) && pre_first;
    end
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
    parameter int HALF_W  = 8,
    parameter int PRE_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [HALF_W-1:0] ma_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic              busy_o,
    input logic              done_o
);
    localparam int HW_CNT = $clog2(PRE_CYC + 3) + 1;
    localparam logic [HW_CNT-1:0] HI_MAX = '1;
    localparam logic [HW_CNT-1:0] HI_MIN = HW_CNT'(PRE_CYC + 2);

    logic [HW_CNT-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= HI_MAX;
        else if (!ras_n_o)
            hi_cnt <= '0;
        else if (hi_cnt != HI_MAX)
            hi_cnt <= hi_cnt + 1'b1;
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ras_n_o && cas_n_o && we_n_o && !done_o));

    assert_row_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> $stable(ma_o));

    assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n_o) |-> (!ras_n_o && $past(!ras_n_o) && $stable(ma_o)));

    assert_col_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cas_n_o && $past(!cas_n_o)) |-> $stable(ma_o));

    assert_rise_together_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n_o) |-> $rose(ras_n_o));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($rose(ras_n_o) && busy_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> (hi_cnt >= HI_MIN));

    assert_we_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cas_n_o && $past(!cas_n_o)) |-> $stable(we_n_o));
endmodule

bind dram_addr_seq dram_seq_checker #(.HALF_W(HALF_W), .PRE_CYC(PRE_CYC)) i_chk (
    .clk(clk), .rst(rst), .ma_o(ma_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_dram_addr_seq.sv
module test_dram_addr_seq;
    localparam int HALF_W  = 8;
    localparam int CAS_CYC = 2;
    localparam int PRE_CYC = 2;
    localparam int AW      = 2 * HALF_W;
    localparam int LAST_K  = 4 + CAS_CYC + PRE_CYC;
    localparam int NVEC    = 6;
    localparam logic [AW:0] VEC [NVEC] = '{
        {1'b0, 16'hA55A}, {1'b1, 16'h1234}, {1'b1, 16'hFF00},
        {1'b0, 16'h00FF}, {1'b0, 16'h0000}, {1'b1, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0, wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [HALF_W-1:0] ma_o;
    logic ras_n_o, cas_n_o, we_n_o, busy_o, done_o;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dram_addr_seq #(.HALF_W(HALF_W), .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)) i_dram_addr_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .ma_o(ma_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({ras_n_o, cas_n_o, we_n_o, busy_o, done_o} == 5'b11100, tag,
              {ras_n_o, cas_n_o, we_n_o, busy_o, done_o}, 5'b11100);
    endtask

    // Walks one access; k counts cycles after the accepting edge.
    task automatic run_access(input logic wr, input logic [AW-1:0] addr, input int poke_k);
        logic [HALF_W-1:0] row, col;
        row = addr[AW-1:HALF_W];
        col = addr[HALF_W-1:0];
        @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = addr;
        @(posedge clk); #1;
        req_i = 1'b0; wr_i = 1'b0; addr_i = '0;
        for (int k = 1; k <= LAST_K; k++) begin
            logic exp_ras, exp_cas, exp_busy, exp_done, exp_we;
            string tag;
            @(negedge clk);
            exp_ras  = !(k >= 2 && k <= 3 + CAS_CYC);
            exp_cas  = !(k >= 4 && k <= 3 + CAS_CYC);
            exp_busy = (k < LAST_K);
            exp_done = (k == 4 + CAS_CYC);
            exp_we   = (k <= 3 + CAS_CYC) ? ~wr : 1'b1;
            if (k == 1)                tag = "R2 row setup";
            else if (k == 2)           tag = "R3 ras fall";
            else if (k == 3)           tag = "R4 column setup";
            else if (k <= 3 + CAS_CYC) tag = "R5 cas window";
            else if (exp_done)         tag = "R6 strobe rise";
            else                       tag = "R7 precharge";
            check({ras_n_o, cas_n_o} == {exp_ras, exp_cas}, tag,
                  {ras_n_o, cas_n_o}, {exp_ras, exp_cas});
            check({busy_o, done_o} == {exp_busy, exp_done}, {tag, " busy/done R6 R7"},
                  {busy_o, done_o}, {exp_busy, exp_done});
            check(we_n_o == exp_we, "R8 write enable", we_n_o, exp_we);
            if (k <= 2)
                check(ma_o == row, "R10 row half", ma_o, row);
            else if (k <= 3 + CAS_CYC)
                check(ma_o == col, "R10 column half", ma_o, col);
            if (k == poke_k) begin
                req_i = 1'b1; wr_i = ~wr; addr_i = ~addr;
            end else if (k == poke_k + 1) begin
                req_i = 1'b0; wr_i = 1'b0; addr_i = '0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");

        for (int v = 0; v < NVEC; v++)
            run_access(VEC[v][AW], VEC[v][AW-1:0], -5);

        // R9: request raised during the access, in the column-setup cycle and in precharge
        run_access(1'b1, 16'h3C5A, 3);
        repeat (3) begin
            @(negedge clk);
            check_idle("R9 no second access");
        end
        run_access(1'b0, 16'h9876, 5 + CAS_CYC);
        repeat (3) begin
            @(negedge clk);
            check_idle("R9 no access after precharge request");
        end

        // R1: reset in the middle of an access
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b1; addr_i = 16'h4242;
        @(posedge clk); #1;
        req_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid access");

        run_access(1'b1, 16'hBEEF, -5);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule